// File: doc/BRIEF.md
# Hamming Sector ECC Unit

This block builds a single-error-correcting Hamming code for one 512-byte sector while the sector's bytes pass over a NAND data bus. It is used the same way for writes and reads. On a write, the sector is streamed and the resulting 24-bit code is stored in spare area. On a read, the sector is streamed again and the new code is handed to the checker together with the stored one.

Two parity groups of 12 bits are kept. The high group is the XOR of the bit addresses (byte index times eight plus bit position) of every data bit that is 1. The low group is the XOR of the bitwise complements of those same addresses. The output code is the inverted concatenation of the two groups. Because of this, an erased sector of all 0xFF bytes produces 0xFFFFFF, which matches erased spare bytes.

The checker registers its verdict. It separates four cases: a clean sector, a single flipped data bit (with its byte and bit position), a single flipped bit inside the stored code, and anything worse.

Top module: `hecc_sector`

## Requirements
- R1: After reset, code_o is 24'hFFFFFF and chk_valid_o is 0.
- R2: code_o is ~{hi, lo}. Bits [11:0] carry lo and bits [23:12] carry hi. hi is the XOR over all 1 data bits since sector start of the 12-bit address {byte_index[8:0], bit[2:0]}, and lo is the XOR of the complements of those addresses. code_o[7:0] is the first code byte to store, [15:8] the second and [23:16] the third.
- R3: A sector of 512 bytes of 0xFF yields code_o = 24'hFFFFFF.
- R4: Each byte accepted with byte_valid_i takes the next byte index. The index starts at 0 and wraps after 511.
- R5: A byte accepted with byte_sos_i high discards earlier accumulation and becomes byte index 0 of a new sector.
- R6: clr_i empties the accumulator (code_o becomes 24'hFFFFFF) and resets the byte index. A byte valid in the same cycle is counted as byte 0 of the new sector.
- R7: code_rd_i marks a read of code_o in that cycle. From the next cycle the accumulator is empty, as for clr_i.
- R8: Without byte_valid_i, clr_i or code_rd_i, code_o holds. byte_data_i and byte_sos_i are then ignored.
- R9: chk_valid_o is high exactly in the cycle after chk_req_i. The status and indices take their new values in that same cycle.
- R10: If diff = chk_calc_i ^ chk_stored_i is zero, the status is 2'b00 and both indices are 0.
- R11: If diff[11:0] ^ diff[23:12] is 12'hFFF and diff[23:15] is below 512, the status is 2'b01, chk_byte_o = diff[23:15] and chk_bit_o = diff[14:12].
- R12: If diff has exactly one bit set, the status is 2'b10 (error in the stored code only) and both indices are 0.
- R13: Any other nonzero diff gives status 2'b11 and both indices are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Restart strobe: empties the accumulator |
| byte_valid_i | input | 1 | A data byte is present this cycle |
| byte_sos_i | input | 1 | The present byte is the first of a sector |
| byte_data_i | input | 8 | Data byte |
| code_rd_i | input | 1 | Code is read this cycle; clears afterwards |
| code_o | output | 24 | Inverted packed code, least significant byte first |
| chk_req_i | input | 1 | Start a comparison |
| chk_stored_i | input | 24 | Code read from spare area |
| chk_calc_i | input | 24 | Code computed on readback |
| chk_valid_o | output | 1 | Comparison result valid |
| chk_status_o | output | 2 | 00 clean, 01 data bit fixed, 10 code bit only, 11 uncorrectable |
| chk_byte_o | output | 9 | Byte index of the bad data bit |
| chk_bit_o | output | 3 | Bit position of the bad data bit |

## Verification
The generator is driven with several sector contents, and each exposes a different fault:
- A pseudo-random sector exposes errors in index counting and in the parity fold.
- An all-zero sector with a single 1 bit checks the packing and byte order exactly.
- An erased sector checks the inversion.
- A run interrupted by a start-of-sector byte, or by a restart with a byte in the same cycle, shows whether old state leaks into the new sector.

The checker is fed the following cases, which together separate the four status codes and the index extraction:
- equal codes;
- the codes of a sector and of a copy with one flipped bit at the first, a middle and the last position;
- codes that differ in a single bit of either group;
- codes that differ by two flipped data bits or by two adjacent code bits.

// File: rtl/hecc_pkg.sv
package hecc_pkg;
  typedef enum logic [1:0] {
    CHK_CLEAN = 2'b00,
    CHK_FIXED = 2'b01,
    CHK_CODE  = 2'b10,
    CHK_FATAL = 2'b11
  } chk_status_e;
endpackage

// File: rtl/hecc_byte_contrib.sv
// Parity contribution of one byte at a given index to both groups.
module hecc_byte_contrib #(
  parameter  int IDX_W = 9,
  localparam int G     = IDX_W + 3
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       data_i,
  output logic [G-1:0]     hi_o,
  output logic [G-1:0]     lo_o
);
  logic       par;
  logic [2:0] bx;

  always_comb begin
    par = ^data_i;
    bx  = '0;
    for (int b = 0; b < 8; b++) begin
      if (data_i[b]) bx = bx ^ 3'(b);
    end
  end

  // odd count of ones: the byte index survives the XOR fold
  assign hi_o = {{IDX_W{par}} & idx_i, bx};
  assign lo_o = {{IDX_W{par}} & ~idx_i, bx ^ {3{par}}};
endmodule

// File: rtl/hecc_accum.sv
module hecc_accum #(
  parameter  int SECTOR_BYTES = 512,
  localparam int IDX_W        = $clog2(SECTOR_BYTES),
  localparam int G            = IDX_W + 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rd_i,
  input  logic         valid_i,
  input  logic         sos_i,
  input  logic [7:0]   data_i,
  output logic [G-1:0] hi_o,
  output logic [G-1:0] lo_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SECTOR_BYTES - 1);

  logic [IDX_W-1:0] idx_q, idx_eff;
  logic [G-1:0]     hi_q, lo_q, c_hi, c_lo;
  logic             restart, fresh;

  assign restart = clr_i | rd_i;
  assign fresh   = restart | (valid_i & sos_i);
  assign idx_eff = fresh ? '0 : idx_q;

  hecc_byte_contrib #(.IDX_W(IDX_W)) u_contrib (
    .idx_i  (idx_eff),
    .data_i (data_i),
    .hi_o   (c_hi),
    .lo_o   (c_lo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q  <= '0;
      lo_q  <= '0;
      idx_q <= '0;
    end else if (valid_i) begin
      hi_q  <= (fresh ? '0 : hi_q) ^ c_hi;
      lo_q  <= (fresh ? '0 : lo_q) ^ c_lo;
      idx_q <= (idx_eff == LAST_IDX) ? '0 : idx_eff + 1'b1;
    end else if (restart) begin
      hi_q  <= '0;
      lo_q  <= '0;
      idx_q <= '0;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R6
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !valid_i |=> hi_q == '0 && lo_q == '0);
  // R7
  rd_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i && !valid_i |=> hi_q == '0 && lo_q == '0);
  // R8
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !restart |=> $stable(hi_q) && $stable(lo_q) && $stable(idx_q));
endmodule

// File: rtl/hecc_checker.sv
module hecc_checker
  import hecc_pkg::*;
#(
  parameter  int SECTOR_BYTES = 512,
  localparam int IDX_W        = $clog2(SECTOR_BYTES),
  localparam int G            = IDX_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [2*G-1:0]   stored_i,
  input  logic [2*G-1:0]   calc_i,
  output logic             valid_o,
  output logic [1:0]       status_o,
  output logic [IDX_W-1:0] byte_o,
  output logic [2:0]       bit_o
);
  localparam logic [IDX_W:0] SEC_LIM = (IDX_W+1)'(SECTOR_BYTES);

  logic [2*G-1:0]   diff;
  logic [G-1:0]     fold;
  chk_status_e      st_d, st_q;
  logic [IDX_W-1:0] byte_d, byte_q;
  logic [2:0]       bit_d, bit_q;
  logic             valid_q;

  assign diff = calc_i ^ stored_i;
  assign fold = diff[G-1:0] ^ diff[2*G-1:G];

  always_comb begin
    st_d   = CHK_FATAL;
    byte_d = '0;
    bit_d  = '0;
    if (diff == '0) begin
      st_d = CHK_CLEAN;
    end else if (&fold) begin
      // groups are exact complements: one data bit flipped
      if ({1'b0, diff[2*G-1:G+3]} < SEC_LIM) begin
        st_d   = CHK_FIXED;
        byte_d = diff[2*G-1:G+3];
        bit_d  = diff[G+2:G];
      end
    end else if ($countones(diff) == 1) begin
      st_d = CHK_CODE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      st_q    <= CHK_CLEAN;
      byte_q  <= '0;
      bit_q   <= '0;
    end else begin
      valid_q <= req_i;
      if (req_i) begin
        st_q   <= st_d;
        byte_q <= byte_d;
        bit_q  <= bit_d;
      end
    end
  end

  assign valid_o  = valid_q;
  assign status_o = st_q;
  assign byte_o   = byte_q;
  assign bit_o    = bit_q;

  // R9
  valid_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  // R9
  valid_only_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  // R10
  clean_zero_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && calc_i == stored_i |=> status_o == 2'b00 && byte_o == '0 && bit_o == '0);
  // R12
  code_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && $countones(calc_i ^ stored_i) == 1 |=> status_o == 2'b10 && byte_o == '0);
  // R11
  fixed_index_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> status_o != 2'b01 ||
              {byte_o, bit_o} == $past(calc_i[2*G-1:G] ^ stored_i[2*G-1:G]));
endmodule

// File: rtl/hecc_sector.sv
module hecc_sector #(
  parameter  int SECTOR_BYTES = 512,
  localparam int IDX_W        = $clog2(SECTOR_BYTES),
  localparam int G            = IDX_W + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             byte_valid_i,
  input  logic             byte_sos_i,
  input  logic [7:0]       byte_data_i,
  input  logic             code_rd_i,
  output logic [2*G-1:0]   code_o,
  input  logic             chk_req_i,
  input  logic [2*G-1:0]   chk_stored_i,
  input  logic [2*G-1:0]   chk_calc_i,
  output logic             chk_valid_o,
  output logic [1:0]       chk_status_o,
  output logic [IDX_W-1:0] chk_byte_o,
  output logic [2:0]       chk_bit_o
);
  logic [G-1:0] acc_hi, acc_lo;

  hecc_accum #(.SECTOR_BYTES(SECTOR_BYTES)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .rd_i    (code_rd_i),
    .valid_i (byte_valid_i),
    .sos_i   (byte_sos_i),
    .data_i  (byte_data_i),
    .hi_o    (acc_hi),
    .lo_o    (acc_lo)
  );

  // inversion makes an erased sector match erased spare bytes
  assign code_o = ~{acc_hi, acc_lo};

  hecc_checker #(.SECTOR_BYTES(SECTOR_BYTES)) u_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (chk_req_i),
    .stored_i (chk_stored_i),
    .calc_i   (chk_calc_i),
    .valid_o  (chk_valid_o),
    .status_o (chk_status_o),
    .byte_o   (chk_byte_o),
    .bit_o    (chk_bit_o)
  );

  // R3
  empty_code_ones_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !byte_valid_i |=> code_o == '1);
endmodule

// File: tb/hecc_sector_test.sv
module hecc_sector_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0, bvalid = 1'b0, bsos = 1'b0, crd = 1'b0, creq = 1'b0;
  logic [7:0]  bdata = '0;
  logic [23:0] code, cstored = '0, ccalc = '0;
  logic        cvalid;
  logic [1:0]  cstatus;
  logic [8:0]  cbyte;
  logic [2:0]  cbit;
  int          n_chk = 0, n_fail = 0;
  logic [7:0]  sec [512];

  always #5 clk = ~clk;

  hecc_sector uut (
    .clk_i(clk), .rst_ni(rst_n), .clr_i(clr), .byte_valid_i(bvalid),
    .byte_sos_i(bsos), .byte_data_i(bdata), .code_rd_i(crd), .code_o(code),
    .chk_req_i(creq), .chk_stored_i(cstored), .chk_calc_i(ccalc),
    .chk_valid_o(cvalid), .chk_status_o(cstatus), .chk_byte_o(cbyte), .chk_bit_o(cbit)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] model(int n);
    logic [11:0] hi = '0, lo = '0;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++)
        if (sec[k][b]) begin
          logic [11:0] a;
          a  = {9'(k), 3'(b)};
          hi = hi ^ a;
          lo = lo ^ ~a;
        end
    return ~{hi, lo};
  endfunction

  task automatic feed(int n, bit sos_first);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      bvalid = 1'b1; bdata = sec[k]; bsos = (k == 0) && sos_first;
    end
    @(negedge clk);
    bvalid = 1'b0; bsos = 1'b0;
  endtask

  task automatic do_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic fill_pattern(int seed);
    for (int k = 0; k < 512; k++) sec[k] = 8'(k * 37 + seed);
  endtask

  task automatic chk(string req, logic [23:0] st, logic [23:0] ca,
                     logic [1:0] es, logic [8:0] eb, logic [2:0] ei);
    @(negedge clk); creq = 1'b1; cstored = st; ccalc = ca;
    @(negedge clk); creq = 1'b0;
    check({req, " valid"}, 32'(cvalid), 32'd1);
    check({req, " status"}, 32'(cstatus), 32'(es));
    check({req, " byte"}, 32'(cbyte), 32'(eb));
    check({req, " bit"}, 32'(cbit), 32'(ei));
  endtask

  task automatic t_reset();
    check("R1 code", 32'(code), 32'hFFFFFF);
    check("R1 valid", 32'(cvalid), 32'd0);
  endtask

  task automatic t_pattern();
    fill_pattern(11);
    feed(512, 1);
    check("R2 pattern", 32'(code), 32'(model(512)));
    for (int k = 0; k < 512; k++) sec[k] = (k % 2 == 0) ? 8'h55 : 8'hAA;
    feed(512, 1);
    check("R2 alternating", 32'(code), 32'(model(512)));
  endtask

  task automatic t_single_bit();
    for (int k = 0; k < 512; k++) sec[k] = 8'h00;
    sec[300] = 8'h20;
    feed(512, 1);
    check("R2 single bit", 32'(code), 32'h69A965);
    check("R2 first byte", 32'(code[7:0]), 32'h65);
  endtask

  task automatic t_erased();
    for (int k = 0; k < 512; k++) sec[k] = 8'hFF;
    feed(512, 1);
    check("R3 erased", 32'(code), 32'hFFFFFF);
  endtask

  task automatic t_wrap();
    // R4: 512 bytes then 3 more without a start mark land on indices 0..2
    fill_pattern(3);
    do_clr();
    feed(512, 0);
    for (int k = 0; k < 3; k++) sec[k] = sec[k] ^ sec[k];
    sec[0] = 8'h01; sec[1] = 8'h80; sec[2] = 8'h07;
    feed(3, 0);
    fill_pattern(3);
    begin
      logic [23:0] e;
      logic [23:0] first = model(512);
      sec[0] = 8'(0 * 37 + 3) ^ 8'h01;
      sec[1] = 8'(1 * 37 + 3) ^ 8'h80;
      sec[2] = 8'(2 * 37 + 3) ^ 8'h07;
      e = model(512);
      check("R4 wrap", 32'(code), 32'(e));
      if (e === first) $display("note: wrap check degenerate");
    end
  endtask

  task automatic t_sos();
    for (int k = 0; k < 100; k++) sec[k] = 8'h5A ^ 8'(k);
    feed(100, 0);
    fill_pattern(11);
    feed(512, 1);
    check("R5 restart on sos", 32'(code), 32'(model(512)));
  endtask

  task automatic t_clr_same();
    fill_pattern(7);
    feed(40, 1);
    @(negedge clk); clr = 1'b1; bvalid = 1'b1; bdata = 8'h80;
    @(negedge clk); clr = 1'b0; bvalid = 1'b0;
    check("R6 clear with byte", 32'(code), 32'hFF8007);
    for (int k = 0; k < 11; k++) sec[k] = 8'h13 + 8'(k);
    sec[0] = 8'h80;
    for (int k = 1; k < 11; k++) begin
      @(negedge clk); bvalid = 1'b1; bdata = sec[k];
    end
    @(negedge clk); bvalid = 1'b0;
    check("R6 index after clear", 32'(code), 32'(model(11)));
    do_clr();
    check("R6 plain clear", 32'(code), 32'hFFFFFF);
  endtask

  task automatic t_read_clear();
    fill_pattern(29);
    feed(512, 1);
    @(negedge clk); crd = 1'b1;
    #1 check("R7 code at read", 32'(code), 32'(model(512)));
    @(negedge clk); crd = 1'b0;
    check("R7 cleared after read", 32'(code), 32'hFFFFFF);
  endtask

  task automatic t_hold();
    fill_pattern(5);
    feed(200, 1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bdata = 8'(i * 17); bsos = i[0];
    end
    @(negedge clk); bsos = 1'b0;
    check("R8 hold", 32'(code), 32'(model(200)));
  endtask

  task automatic t_chk_clean();
    chk("R10 clean", 24'h123456, 24'h123456, 2'b00, 9'd0, 3'd0);
    @(negedge clk);
    check("R9 valid drops", 32'(cvalid), 32'd0);
  endtask

  task automatic t_chk_data();
    logic [23:0] good;
    fill_pattern(11);
    good = model(512);
    sec[300] = sec[300] ^ 8'h20;
    feed(512, 1);
    chk("R11 data bit 300.5", good, code, 2'b01, 9'd300, 3'd5);
    sec[300] = sec[300] ^ 8'h20;
    sec[0] = sec[0] ^ 8'h01;
    chk("R11 data bit 0.0", good, model(512), 2'b01, 9'd0, 3'd0);
    sec[0] = sec[0] ^ 8'h01;
    sec[511] = sec[511] ^ 8'h80;
    chk("R11 data bit 511.7", model(512), good, 2'b01, 9'd511, 3'd7);
  endtask

  task automatic t_chk_code();
    chk("R12 code bit low", 24'hABCDEF, 24'hABCDEF ^ 24'h000400, 2'b10, 9'd0, 3'd0);
    chk("R12 code bit high", 24'h000000, 24'h800000, 2'b10, 9'd0, 3'd0);
  endtask

  task automatic t_chk_multi();
    logic [23:0] good;
    fill_pattern(11);
    good = model(512);
    sec[10] = sec[10] ^ 8'h04;
    sec[400] = sec[400] ^ 8'h40;
    chk("R13 two data bits", good, model(512), 2'b11, 9'd0, 3'd0);
    chk("R13 two code bits", 24'h000000, 24'h000003, 2'b11, 9'd0, 3'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pattern();
    t_single_bit();
    t_erased();
    t_wrap();
    t_sos();
    t_clr_same();
    t_read_clear();
    t_hold();
    t_chk_clean();
    t_chk_data();
    t_chk_code();
    t_chk_multi();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule